// File: doc/BRIEF.md
# Fixed-to-Float Number Converter

This combinational block turns a signed fixed-point number into a small floating-point pair. The input is a 7-bit two's complement word with two fraction bits. The output is a 4-bit two's complement mantissa with one fraction bit, plus a two's complement exponent. The value the output represents is the mantissa times two to the power of the exponent.

The block finds the first bit below the sign that differs from the sign. It shifts the input left until that bit sits just under the mantissa's sign bit, and keeps the top four bits. It then sets the exponent from the shift distance. Any low bits that do not fit are truncated, so the result always moves toward minus infinity. A zero input gives a defined all-zero output.

The block has no clock, reset or handshake. The output follows the input within the same cycle.

Top module: `fx2fl_conv`

## Requirements
- R1: `in_i` is read as a 7-bit two's complement integer. The number it represents is that integer divided by 4.
- R2: `mant_o` is a 4-bit two's complement integer whose value is that integer divided by 2. For every nonzero input, the sign bit of `mant_o` (bit 3) equals the sign bit of `in_i` (bit 6).
- R3: For every nonzero input, `mant_o` is normalized, meaning bit 3 differs from bit 2. Positive mantissas therefore lie in 2.0..3.5 and negative ones in -4.0..-2.5.
- R4: For every nonzero input, `mant_o`/2 × 2^`exp_o` equals the largest value on that mantissa grid that does not exceed `in_i`/4. In integer terms, `mant_o` = floor(`in_i` × 8 / 2^(`exp_o`+4)).
- R5: An input of 0 gives `mant_o` = 0000 and `exp_o` = 000.
- R6: `exp_o` is a 3-bit two's complement integer in the range -4..+2. Raw input 1 (0.25) gives exponent -3. Raw -1 (-0.25) gives mantissa 1000 with exponent -4. Raw 63 (15.75) gives mantissa 0111 with exponent +2.
- R7: An input with no more than four significant bits is reproduced exactly. For example, raw -64 (-16) gives mantissa 1000 with exponent +2.
- R8: Dropped bits of a negative input lower its value. For example, raw -63 (-15.75) gives mantissa 1000 with exponent +2, which is -16.
- R9: The outputs depend only on the present input, with no clock and no internal state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_i | input | 7 | Signed fixed-point input, two fraction bits |
| mant_o | output | 4 | Signed normalized mantissa, one fraction bit |
| exp_o | output | 3 | Signed exponent, base two |

## Verification
Normalization and truncation act in the same evaluation whenever the input has more than four significant bits. The shift decides which bits survive, and the truncation then moves the kept value down. This is sharpest for large negative inputs such as -15.75, where the discarded ones carry the result across a power of two. The bench provokes it with directed values at both ends of the range and with a full sweep of all 128 codes. It judges each result against a floor-division model that searches for the one exponent giving a normalized mantissa.

// File: rtl/fx2fl_pkg.sv
package fx2fl_pkg;
  localparam int IN_W      = 7;
  localparam int IN_FRAC   = 2;
  localparam int MANT_W    = 4;
  localparam int MANT_FRAC = 1;
  localparam int EXP_W     = 3;
endpackage

// File: rtl/fx2fl_lead.sv
// Distance from the sign bit to the first bit that differs from it.
module fx2fl_lead #(
  parameter int W  = 7,
  parameter int SW = 3
) (
  input  logic [W-1:0]  in_i,
  output logic [SW-1:0] shamt_o,
  output logic          zero_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    shamt_o = '0;
    zero_o  = 1'b0;
    for (int i = W - 2; i >= 0; i--) begin
      if (!found && (in_i[i] ^ in_i[W-1])) begin
        found   = 1'b1;
        shamt_o = SW'(W - 2 - i);
      end
    end
    if (!found) begin
      // all ones: shifting in zeros still normalizes to 10..0
      if (in_i[W-1]) shamt_o = SW'(W - 1);
      else           zero_o  = 1'b1;
    end
  end

  always_comb begin
    if (!$isunknown(in_i)) begin
      assert_shamt_range_R3: assert (int'(shamt_o) <= W - 1);
      assert_zero_detect_R5: assert (zero_o == (in_i == '0));
    end
  end
endmodule

// File: rtl/fx2fl_shift.sv
// Logarithmic left shifter that fills with zeros.
module fx2fl_shift #(
  parameter int W  = 7,
  parameter int SW = 3
) (
  input  logic [W-1:0]  in_i,
  input  logic [SW-1:0] shamt_i,
  output logic [W-1:0]  out_o
);
  logic [W-1:0] stage [SW+1];

  assign stage[0] = in_i;

  for (genvar g = 0; g < SW; g++) begin : g_stage
    assign stage[g+1] = shamt_i[g] ? (stage[g] << (2 ** g)) : stage[g];
  end

  assign out_o = stage[SW];
endmodule

// File: rtl/fx2fl_exp.sv
// Exponent = bias - shift distance.
module fx2fl_exp #(
  parameter int SW   = 3,
  parameter int EW   = 3,
  parameter int BIAS = 2,
  parameter int MAXS = 6
) (
  input  logic [SW-1:0] shamt_i,
  output logic [EW-1:0] exp_o
);
  assign exp_o = EW'(BIAS) - EW'(shamt_i);

  always_comb begin
    if (!$isunknown(shamt_i) && int'(shamt_i) <= MAXS) begin
      assert_exp_range_R6: assert (int'($signed(exp_o)) >= BIAS - MAXS &&
                                   int'($signed(exp_o)) <= BIAS);
    end
  end
endmodule

// File: rtl/fx2fl_conv.sv
module fx2fl_conv
  import fx2fl_pkg::*;
#(
  parameter int IW = IN_W,
  parameter int IF = IN_FRAC,
  parameter int MW = MANT_W,
  parameter int MF = MANT_FRAC,
  parameter int EW = EXP_W
) (
  input  logic [IW-1:0] in_i,
  output logic [MW-1:0] mant_o,
  output logic [EW-1:0] exp_o
);
  localparam int SW   = $clog2(IW);
  localparam int BIAS = IW - MW + MF - IF;

  logic [SW-1:0] shamt;
  logic          zero;
  logic [IW-1:0] shifted;
  logic [EW-1:0] exp_raw;

  fx2fl_lead #(.W(IW), .SW(SW)) u_lead (
    .in_i   (in_i),
    .shamt_o(shamt),
    .zero_o (zero)
  );

  fx2fl_shift #(.W(IW), .SW(SW)) u_shift (
    .in_i   (in_i),
    .shamt_i(shamt),
    .out_o  (shifted)
  );

  fx2fl_exp #(.SW(SW), .EW(EW), .BIAS(BIAS), .MAXS(IW - 1)) u_exp (
    .shamt_i(shamt),
    .exp_o  (exp_raw)
  );

  // truncation: the low IW-MW bits of the shifted word are dropped
  assign mant_o = zero ? '0 : shifted[IW-1 -: MW];
  assign exp_o  = zero ? '0 : exp_raw;

  always_comb begin
    if (!$isunknown(in_i)) begin
      assert_zero_out_R5: assert (in_i != '0 || (mant_o == '0 && exp_o == '0));
      assert_normalized_R3: assert (in_i == '0 || mant_o[MW-1] != mant_o[MW-2]);
      assert_sign_kept_R2: assert (in_i == '0 || mant_o[MW-1] == in_i[IW-1]);
    end
  end
endmodule

// File: tb/fx2fl_conv_tb.sv
module fx2fl_conv_tb;
  logic       clk;
  logic       rst_ni;
  logic [6:0] in_i;
  logic [3:0] mant_o;
  logic [2:0] exp_o;
  int         n_tests;
  int         n_fail;
  bit         done;

  fx2fl_conv u_dut (.in_i(in_i), .mant_o(mant_o), .exp_o(exp_o));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Independent model: find the one exponent whose floor quotient is normalized.
  function automatic void model(input int x, output int m, output int e);
    m = 0; e = 0;
    if (x == 0) return;
    for (int k = -4; k <= 2; k++) begin
      int q;
      q = (x * 8) >>> (k + 4);
      if ((q >= 4 && q <= 7) || (q >= -8 && q <= -5)) begin
        m = q; e = k;
      end
    end
  endfunction

  task automatic apply(input int x);
    @(negedge clk);
    in_i = 7'(x);
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int x, input int m_exp, input int e_exp);
    int m_act, e_act;
    m_act = int'($signed(mant_o));
    e_act = int'($signed(exp_o));
    n_tests++;
    if (m_act != m_exp || e_act != e_exp) begin
      n_fail++;
      $display("FAIL %s in=%0d mant=%0d exp=%0d expected mant=%0d exp=%0d",
               req, x, m_act, e_act, m_exp, e_exp);
    end
  endtask

  task automatic t_reset_state();
    in_i = '0;
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R5", 0, 0, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_zero();
    apply(5); apply(0);
    check("R5", 0, 0, 0);
  endtask

  task automatic t_extremes();
    apply(1);   check("R6", 1, 4, -3);
    apply(-1);  check("R6", -1, -8, -4);
    apply(63);  check("R6", 63, 7, 2);
    apply(-64); check("R7", -64, -8, 2);
  endtask

  task automatic t_exact();
    apply(8);   check("R7", 8, 4, 0);
    apply(-12); check("R7", -12, -6, 0);
    apply(56);  check("R7", 56, 7, 2);
    apply(2);   check("R1", 2, 4, -2);
  endtask

  task automatic t_neg_trunc();
    apply(-63); check("R8", -63, -8, 2);
    apply(-13); check("R8", -13, -7, 0);
    apply(15);  check("R4", 15, 7, 0);
    apply(-33); check("R8", -33, -5, 2);
  endtask

  task automatic t_sweep();
    for (int x = -64; x < 64; x++) begin
      int m, e;
      apply(x);
      model(x, m, e);
      check("R4", x, m, e);
      if (x != 0) begin
        n_tests++;
        if (mant_o[3] == mant_o[2] || mant_o[3] != in_i[6]) begin
          n_fail++;
          $display("FAIL R3 in=%0d mant=%b expected normalized with sign %b", x, mant_o, in_i[6]);
        end
      end
    end
  endtask

  // R9: no clock reaches the block; the output must settle within the input change
  task automatic t_comb();
    @(negedge clk);
    in_i = 7'(20);
    #1;
    check("R9", 20, 5, 1);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    t_reset_state();
    t_zero();
    t_extremes();
    t_exact();
    t_neg_trunc();
    t_comb();
    t_sweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule